// File: doc/BRIEF.md
# Device Write Attribute Checker

This block sits on the write path between a requester and a memory-mapped device fabric. Each write carries an address, data, byte strobes and a 2-bit device-memory attribute. The attribute tells the fabric whether writes may be gathered, reordered, or completed early. The block decodes which region the address falls in and checks the attribute against that region's rule. Compliant writes are passed downstream. Non-compliant writes are discarded and reported.

On-chip peripheral windows accept only the strictest attribute, which has no gathering, no reordering and no early acknowledgement. Their writes are non-posted, so the requester gets its response only after the downstream side acknowledges the write. The PCIe window accepts only the attribute that allows early acknowledgement and nothing weaker. A write there with the strictest attribute is also refused. An accepted PCIe write is posted: the requester is answered in the cycle the write is taken, while the data is still held for the fabric.

A refused write, or a write to an address outside every window, is answered with an error response. It also sets a sticky error flag that holds the address of the first offending write until software clears it.

Top module: `dev_wr_guard`

## Requirements
- R1: The attribute encoding is 2'b00 = no gather, no reorder, no early ack; 2'b01 = no gather, no reorder, early ack; 2'b10 = no gather, reorder, early ack; 2'b11 = gather, reorder, early ack. A write that hits a peripheral window with attribute 2'b00 appears on the downstream side one cycle after acceptance, with the same address, data and strobes and with dn_posted = 0.
- R2: A write that hits a peripheral window with any attribute other than 2'b00 is dropped. In its acceptance cycle it gets rsp_valid = 1 with rsp_err = 1, and dn_valid stays 0.
- R3: A write that hits the PCIe window with attribute 2'b01 is forwarded with dn_posted = 1. It gets rsp_valid = 1 with rsp_err = 0 in its acceptance cycle.
- R4: A write to the PCIe window with attribute 2'b00, 2'b10 or 2'b11 is dropped, with the same response and downstream behaviour as R2.
- R5: A write whose address lies in no window is dropped, with the same response and downstream behaviour as R2. Window bounds are inclusive, and peripheral windows take precedence over the PCIe window.
- R6: A non-posted write is answered with rsp_valid = 1 and rsp_err = 0 only in the cycle dn_ack is high after its downstream handshake. dn_ack at any other time produces no response.
- R7: A drop sets err_flag in the following cycle and loads err_addr with the dropped address. Later drops leave err_addr unchanged while the flag is set.
- R8: err_clr clears err_flag in the next cycle. A drop in the same cycle as err_clr leaves the flag set and captures the new address.
- R9: While a forwarded write is waiting for dn_ready or dn_ack, req_ready is 0. dn_valid and the downstream payload are held stable until dn_ready.
- R10: After reset, req_ready = 1, dn_valid = 0, rsp_valid = 0 and err_flag = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_strb | input | DW/8 | Byte strobes |
| req_attr | input | 2 | Device memory attribute (R1 encoding) |
| rsp_valid | output | 1 | Write response pulse |
| rsp_err | output | 1 | Response marks a dropped write |
| dn_valid | output | 1 | Downstream write present |
| dn_ready | input | 1 | Downstream takes the write |
| dn_addr | output | AW | Downstream address |
| dn_data | output | DW | Downstream data |
| dn_strb | output | DW/8 | Downstream strobes |
| dn_posted | output | 1 | Downstream write is posted |
| dn_ack | input | 1 | Downstream completion of a non-posted write |
| err_flag | output | 1 | Sticky error flag |
| err_addr | output | AW | Address of the first dropped write |
| err_clr | input | 1 | Clears the error flag |

## Verification
The bench sweeps every attribute against addresses at each window edge and one address past each edge. A decoder with an off-by-one bound would then forward or drop the wrong write. A one-sided rule would let the strict attribute through to PCIe, or let weaker attributes reach a peripheral. Posted and non-posted writes are timed separately: a design that acknowledged a peripheral write early, or made a PCIe write wait, would show the response in the wrong cycle. The bench also issues a drop in the same cycle as a clear. A capture that gave the clear priority would lose the new address.

// File: rtl/dwg_pkg.sv
// Package: shared types for the device write attribute checker.
// Assumes a 2-bit attribute field on the request side.
package dwg_pkg;
    // Device memory attribute, strictest first
    typedef enum logic [1:0] {
        ATTR_NG_NR_NE = 2'b00,
        ATTR_NG_NR_E  = 2'b01,
        ATTR_NG_R_E   = 2'b10,
        ATTR_G_R_E    = 2'b11
    } dev_attr_e;

    // Region class of an address
    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_PERIPH = 2'd1,
        REG_PCIE   = 2'd2
    } region_e;

    // Forwarding state
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WACK = 2'd2
    } fwd_state_e;
endpackage

// File: rtl/dwg_region_decode.sv
// Module: maps an address to a region class.
// Assumes inclusive bounds; peripheral windows win over the PCIe window.
module dwg_region_decode
    import dwg_pkg::*;
#(
    parameter int AW = 16,
    parameter int NPERIPH = 2,
    parameter logic [NPERIPH*AW-1:0] PERIPH_BASE = {16'h3000, 16'h1000},
    parameter logic [NPERIPH*AW-1:0] PERIPH_LAST = {16'h33FF, 16'h1FFF},
    parameter logic [AW-1:0] PCIE_BASE = 16'h8000,
    parameter logic [AW-1:0] PCIE_LAST = 16'hBFFF
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    logic [NPERIPH-1:0] win_hit;

    // One comparator pair per peripheral window
    for (genvar g = 0; g < NPERIPH; g++) begin : g_win
        localparam logic [AW-1:0] LO = PERIPH_BASE[g*AW +: AW];
        localparam logic [AW-1:0] HI = PERIPH_LAST[g*AW +: AW];
        assign win_hit[g] = (addr >= LO) && (addr <= HI);
    end

    logic pcie_hit;
    assign pcie_hit = (addr >= PCIE_BASE) && (addr <= PCIE_LAST);

    // Priority select of the region class
    always_comb begin
        if (|win_hit)     region = REG_PERIPH;
        else if (pcie_hit) region = REG_PCIE;
        else               region = REG_NONE;
    end
endmodule

// File: rtl/dwg_attr_rule.sv
// Module: decides whether an attribute is legal for a region.
// Peripherals need the strictest type; PCIe needs exactly early-ack, no gather/reorder.
module dwg_attr_rule
    import dwg_pkg::*;
(
    input  region_e   region,
    input  dev_attr_e attr,
    output logic      allow,
    output logic      posted
);
    // Exact-match rule per region, both directions refused
    always_comb begin
        allow  = 1'b0;
        posted = 1'b0;
        unique case (region)
            REG_PERIPH: allow = (attr == ATTR_NG_NR_NE);
            REG_PCIE: begin
                allow  = (attr == ATTR_NG_NR_E);
                posted = 1'b1;
            end
            default: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/dwg_fwd.sv
// Module: accepts requests, holds forwarded writes for the fabric and
// generates responses. Assumes one outstanding write at a time.
module dwg_fwd
    import dwg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [SW-1:0] req_strb,
    input  logic          allow,
    input  logic          posted,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic          drop,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [SW-1:0] dn_strb,
    output logic          dn_posted,
    input  logic          dn_ack
);
    fwd_state_e state;
    logic       take;

    assign req_ready = (state == ST_IDLE);
    assign take      = req_valid && req_ready;
    assign drop      = take && !allow;
    assign dn_valid  = (state == ST_SEND);

    // Response: drops and posted writes at acceptance, non-posted on ack
    always_comb begin
        rsp_valid = (take && (!allow || posted)) || ((state == ST_WACK) && dn_ack);
        rsp_err   = drop;
    end

    // State sequencing for a single forwarded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (take && allow) state <= ST_SEND;
                ST_SEND: if (dn_ready) state <= dn_posted ? ST_IDLE : ST_WACK;
                ST_WACK: if (dn_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Payload hold register, loaded on an allowed acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_addr   <= '0;
            dn_data   <= '0;
            dn_strb   <= '0;
            dn_posted <= 1'b0;
        end else if (take && allow) begin
            dn_addr   <= req_addr;
            dn_data   <= req_data;
            dn_strb   <= req_strb;
            dn_posted <= posted;
        end
    end
endmodule

// File: rtl/dwg_err_capture.sv
// Module: sticky error flag with first-offender address.
// Assumes a drop in a clearing cycle should be kept.
module dwg_err_capture #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drop,
    input  logic [AW-1:0] drop_addr,
    input  logic          err_clr,
    output logic          err_flag,
    output logic [AW-1:0] err_addr
);
    // Capture first drop; clear on request unless a drop coincides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (drop && (!err_flag || err_clr)) begin
            err_flag <= 1'b1;
            err_addr <= drop_addr;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dev_wr_guard.sv
// Module: top of the device write attribute checker.
// Decodes the region, applies the attribute rule, forwards or drops the
// write and records errors. Assumes requests hold stable while unaccepted.
module dev_wr_guard
    import dwg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NPERIPH = 2,
    parameter logic [NPERIPH*AW-1:0] PERIPH_BASE = {16'h3000, 16'h1000},
    parameter logic [NPERIPH*AW-1:0] PERIPH_LAST = {16'h33FF, 16'h1FFF},
    parameter logic [AW-1:0] PCIE_BASE = 16'h8000,
    parameter logic [AW-1:0] PCIE_LAST = 16'hBFFF,
    localparam int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic [SW-1:0] req_strb,
    input  logic [1:0]    req_attr,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [AW-1:0] dn_addr,
    output logic [DW-1:0] dn_data,
    output logic [SW-1:0] dn_strb,
    output logic          dn_posted,
    input  logic          dn_ack,
    output logic          err_flag,
    output logic [AW-1:0] err_addr,
    input  logic          err_clr
);
    region_e region;
    logic    allow;
    logic    posted;
    logic    drop;

    dwg_region_decode #(
        .AW(AW), .NPERIPH(NPERIPH),
        .PERIPH_BASE(PERIPH_BASE), .PERIPH_LAST(PERIPH_LAST),
        .PCIE_BASE(PCIE_BASE), .PCIE_LAST(PCIE_LAST)
    ) u_dec (
        .addr(req_addr), .region(region)
    );

    dwg_attr_rule u_rule (
        .region(region), .attr(dev_attr_e'(req_attr)),
        .allow(allow), .posted(posted)
    );

    dwg_fwd #(.AW(AW), .DW(DW)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_strb(req_strb),
        .allow(allow), .posted(posted),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .drop(drop),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_addr(dn_addr), .dn_data(dn_data), .dn_strb(dn_strb),
        .dn_posted(dn_posted), .dn_ack(dn_ack)
    );

    dwg_err_capture #(.AW(AW)) u_err (
        .clk(clk), .rst_n(rst_n),
        .drop(drop), .drop_addr(req_addr), .err_clr(err_clr),
        .err_flag(err_flag), .err_addr(err_addr)
    );
endmodule

// File: rtl/dwg_checker.sv
// Module: protocol checker bound to dev_wr_guard; observes ports only.
module dwg_checker #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter logic [AW-1:0] PCIE_BASE = 16'h8000,
    parameter logic [AW-1:0] PCIE_LAST = 16'hBFFF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic          dn_valid,
    input logic          dn_ready,
    input logic [AW-1:0] dn_addr,
    input logic [DW-1:0] dn_data,
    input logic          dn_posted,
    input logic          err_flag,
    input logic [AW-1:0] err_addr,
    input logic          err_clr
);
    AST_DROP_NO_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && rsp_valid && rsp_err) |=> !dn_valid); // R2
    AST_POSTED_IN_PCIE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_posted) |-> (dn_addr >= PCIE_BASE && dn_addr <= PCIE_LAST)); // R3
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |=> err_flag); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_addr))); // R7
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(rsp_valid && rsp_err)) |=> !err_flag); // R8
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data))); // R9
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !req_ready); // R9
endmodule

bind dev_wr_guard dwg_checker #(
    .AW(AW), .DW(DW), .PCIE_BASE(PCIE_BASE), .PCIE_LAST(PCIE_LAST)
) u_chk (.*);

// File: tb/dev_wr_guard_bench.sv
module dev_wr_guard_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [SW-1:0] req_strb = '0;
    logic [1:0]    req_attr = '0;
    logic          rsp_valid, rsp_err;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_data;
    logic [SW-1:0] dn_strb;
    logic          dn_posted;
    logic          dn_ack = 1'b0;
    logic          err_flag;
    logic [AW-1:0] err_addr;
    logic          err_clr = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dev_wr_guard u_dev_wr_guard (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bench's own window map: 0 none, 1 peripheral, 2 PCIe
    function automatic int region_of(input logic [AW-1:0] a);
        if ((a >= 16'h1000 && a <= 16'h1FFF) || (a >= 16'h3000 && a <= 16'h33FF)) return 1;
        if (a >= 16'h8000 && a <= 16'hBFFF) return 2;
        return 0;
    endfunction

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic one_write(input logic [AW-1:0] a, input logic [1:0] at, input int idx);
        int  rg = region_of(a);
        bit  ok = (rg == 1 && at == 2'b00) || (rg == 2 && at == 2'b01);
        bit  pst = (rg == 2);
        string rq = !ok ? (rg == 0 ? "R5" : (rg == 1 ? "R2" : "R4")) : (pst ? "R3" : "R1");
        logic [DW-1:0] d = 32'hA5000000 ^ (idx * 32'h01010101);
        logic [SW-1:0] s = SW'(idx + 1);
        clear_err();
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_attr = at; req_data = d; req_strb = s;
        #1;
        chk(req_ready == 1'b1, "R10", "ready_idle", req_ready, 1);
        chk(rsp_valid == (!ok || pst), rq, "rsp_valid_accept", rsp_valid, (!ok || pst));
        chk(rsp_err == !ok, rq, "rsp_err", rsp_err, !ok);
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            chk(dn_valid == 1'b0, rq, "dn_valid_drop", dn_valid, 0);
            chk(err_flag == 1'b1, "R7", "err_flag", err_flag, 1);
            chk(err_addr == a, "R7", "err_addr", err_addr, a);
        end else begin
            chk(dn_valid == 1'b1, rq, "dn_valid", dn_valid, 1);
            chk(dn_addr == a && dn_data == d && dn_strb == s, rq, "payload", dn_addr, a);
            chk(dn_posted == pst, rq, "dn_posted", dn_posted, pst);
            chk(err_flag == 1'b0, rq, "no_err", err_flag, 0);
            @(negedge clk);
            chk(dn_valid == 1'b1 && dn_addr == a, "R9", "hold_stall", dn_valid, 1);
            chk(req_ready == 1'b0, "R9", "busy", req_ready, 0);
            dn_ready = 1'b1;
            @(negedge clk);
            dn_ready = 1'b0;
            #1;
            chk(dn_valid == 1'b0, "R9", "dn_released", dn_valid, 0);
            if (pst) begin
                chk(req_ready == 1'b1, "R3", "posted_free", req_ready, 1);
                chk(rsp_valid == 1'b0, "R3", "no_late_rsp", rsp_valid, 0);
            end else begin
                chk(req_ready == 1'b0, "R6", "wait_ack", req_ready, 0);
                chk(rsp_valid == 1'b0, "R6", "no_early_rsp", rsp_valid, 0);
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R6", "still_no_rsp", rsp_valid, 0);
                dn_ack = 1'b1;
                #1;
                chk(rsp_valid == 1'b1 && rsp_err == 1'b0, "R6", "ack_rsp", rsp_valid, 1);
                @(negedge clk);
                dn_ack = 1'b0;
                #1;
                chk(req_ready == 1'b1, "R6", "ready_after_ack", req_ready, 1);
            end
        end
    endtask

    task automatic drop_at(input logic [AW-1:0] a, input bit clr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_attr = 2'b11; err_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; err_clr = 1'b0;
    endtask

    initial begin
        logic [AW-1:0] pts [14] = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000,
                                    16'h2FFF, 16'h3000, 16'h33FF, 16'h3400, 16'h7FFF,
                                    16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
        int n = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10", "reset_ready", req_ready, 1);
        chk(dn_valid == 1'b0 && rsp_valid == 1'b0, "R10", "reset_outs", dn_valid, 0);
        chk(err_flag == 1'b0, "R10", "reset_err", err_flag, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep attributes over window edges (R1..R5)
        for (int i = 0; i < 14; i++) begin
            for (int t = 0; t < 4; t++) begin
                one_write(pts[i], 2'(t), n);
                n++;
            end
        end

        // R6: ack while idle produces no response
        @(negedge clk); dn_ack = 1'b1; #1;
        chk(rsp_valid == 1'b0, "R6", "idle_ack", rsp_valid, 0);
        @(negedge clk); dn_ack = 1'b0;

        // R7: first offender is kept
        clear_err();
        drop_at(16'h0123, 1'b0);
        drop_at(16'h4567, 1'b0);
        chk(err_flag == 1'b1, "R7", "sticky_flag", err_flag, 1);
        chk(err_addr == 16'h0123, "R7", "first_addr", err_addr, 16'h0123);

        // R8: drop coincident with clear captures the new address
        drop_at(16'h89AB, 1'b1);
        chk(err_flag == 1'b1, "R8", "clr_drop_flag", err_flag, 1);
        chk(err_addr == 16'h89AB, "R8", "clr_drop_addr", err_addr, 16'h89AB);
        clear_err();
        chk(err_flag == 1'b0, "R8", "cleared", err_flag, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule